// File: doc/BRIEF.md
# Merged-State Multi-Pattern Byte Matcher

This block scans a byte stream against a set of up to 32 string patterns, one byte per clock, with no backpressure. It walks a compressed goto/failure automaton in which states that look alike across patterns are shared. A shared state does not say by itself which pattern led into it, so every state holds a path mask with one bit per pattern, and an accepting state also holds a final flag. The engine keeps a running path register: the AND of the masks seen along the current walk. A shared accepting state therefore reports only the patterns that were actually traversed, and no false hit comes from a prefix of a different pattern.

Software loads the automaton through a single write port. A state write stores the path mask, the final flag and the failure target of one state. A transition write stores one goto edge (source state, input byte, target state) into a hashed edge table. The pattern compiler runs offline. It must number the states so that no two edges share a hash slot. The stream input must be idle while tables are written.

Top module: `merged_matcher`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `match_o` is 0 and `match_vec_o` is all zero. The engine starts in root state 0 with the path register cleared.
- R2: For a byte accepted at clock edge N, the match result appears on `match_o` and `match_vec_o` after edge N and is held until edge N+1. `match_o` is 1 exactly when the entered state has its final flag set and the updated path register is nonzero. In that case `match_vec_o` equals the updated path register, with bit k meaning pattern k.
- R3: When the current state has a goto edge for the byte, that edge is followed. The path register is loaded with the target's mask if it was zero, and otherwise becomes its AND with the target's mask.
- R4: With "bcdf" as pattern 0 and "pcdg" as pattern 1 sharing the states for "cd", the input "pcdg" reports vector 0b10 and the input "pcdf" reports no match.
- R5: On a byte with no goto edge while the path register is nonzero, the engine takes the failure target of the current state. It follows that target's edge for the same byte if one exists. Otherwise it follows the root's edge for the byte, and otherwise it lands on root. The path register becomes the mask of the landing state, and landing on root clears it.
- R6: On a byte with no goto edge while the path register is zero, the engine follows the root's edge for that byte, or else lands on root. The path register becomes the landing state's mask.
- R7: A cycle with `valid_i` low changes neither the state nor the path register, and the next cycle shows `match_o` low.
- R8: When `tbl_we_i` is 1, `tbl_kind_i` = 0 writes the mask, final flag and failure target of state `tbl_state_i`. `tbl_kind_i` = 1 writes edge (`tbl_state_i`, `tbl_byte_i`) → `tbl_next_i` into slot (state XOR (byte << 2)) mod 1024, for the default sizes, and replaces any edge held there. A lookup hits only if the stored source state and byte both equal the key. Writes take place only while `valid_i` is 0.
- R9: An accepting state entered with a zero path register reports nothing, for example "bcdg", where pattern 0's walk reaches pattern 1's final state.
- R10: `match_vec_o` is all zero whenever `match_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Stream byte present this cycle |
| byte_i | input | 8 | Stream byte |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_kind_i | input | 1 | 0 = state entry, 1 = goto edge |
| tbl_state_i | input | 10 | State index or edge source |
| tbl_path_i | input | 32 | Path mask for a state entry |
| tbl_final_i | input | 1 | Final flag for a state entry |
| tbl_fail_i | input | 10 | Failure target for a state entry |
| tbl_byte_i | input | 8 | Edge input byte |
| tbl_next_i | input | 10 | Edge target state |
| match_o | output | 1 | Match strobe for the previous byte |
| match_vec_o | output | 32 | Patterns matched, one bit per pattern |

## Verification
The assertions assume that the table write strobe never coincides with a valid stream byte, and they flag any cycle where it does. They also assume the loaded tables send nothing into root through a goto edge with a nonzero mask. The bench writes all tables while the stream is held idle. It builds an automaton whose edges fall into distinct hash slots, except for one deliberate eviction at the end. Random bytes are then drawn from that automaton's alphabet plus one byte that has no edges, with idle cycles mixed in.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int BYTE_W = 8;
  localparam logic KIND_STATE = 1'b0;
  localparam logic KIND_TRANS = 1'b1;

  typedef enum logic {
    NS_GOTO = 1'b0,
    NS_FAIL = 1'b1
  } ns_sel_e;
endpackage

// File: rtl/mm_state_tbl.sv
module mm_state_tbl #(
  parameter int NUM_STATES = 1024,
  parameter int NUM_PAT    = 32,
  localparam int SW = $clog2(NUM_STATES)
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [SW-1:0]      wr_idx_i,
  input  logic [NUM_PAT-1:0] wr_path_i,
  input  logic               wr_final_i,
  input  logic [SW-1:0]      wr_fail_i,
  input  logic [SW-1:0]      fail_idx_i,
  output logic [SW-1:0]      fail_o,
  input  logic [SW-1:0]      attr_idx_i,
  output logic [NUM_PAT-1:0] attr_path_o,
  output logic               attr_final_o
);
  logic [NUM_PAT-1:0] path_mem  [NUM_STATES];
  logic               final_mem [NUM_STATES];
  logic [SW-1:0]      fail_mem  [NUM_STATES];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      path_mem[wr_idx_i]  <= wr_path_i;
      final_mem[wr_idx_i] <= wr_final_i;
      fail_mem[wr_idx_i]  <= wr_fail_i;
    end
  end

  assign fail_o       = fail_mem[fail_idx_i];
  assign attr_path_o  = path_mem[attr_idx_i];
  assign attr_final_o = final_mem[attr_idx_i];
endmodule

// File: rtl/mm_trans_tbl.sv
module mm_trans_tbl #(
  parameter int NUM_STATES  = 1024,
  parameter int TRANS_DEPTH = 1024,
  parameter int NUM_RD      = 3,
  localparam int SW = $clog2(NUM_STATES),
  localparam int TW = $clog2(TRANS_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SW-1:0]     wr_state_i,
  input  logic [7:0]        wr_byte_i,
  input  logic [SW-1:0]     wr_next_i,
  input  logic [SW-1:0]     rd_state_i [NUM_RD],
  input  logic [7:0]        rd_byte_i  [NUM_RD],
  output logic [NUM_RD-1:0] rd_hit_o,
  output logic [SW-1:0]     rd_next_o  [NUM_RD]
);
  localparam int SHIFT = (TW > 8) ? TW - 8 : 0;

  // R8: slot = state ^ (byte << SHIFT); the offline compiler avoids collisions
  function automatic logic [TW-1:0] slot_of(input logic [SW-1:0] s, input logic [7:0] b);
    return TW'(s) ^ (TW'(b) << SHIFT);
  endfunction

  logic [TRANS_DEPTH-1:0] valid_q;
  logic [SW-1:0]          tag_s_mem [TRANS_DEPTH];
  logic [7:0]             tag_b_mem [TRANS_DEPTH];
  logic [SW-1:0]          next_mem  [TRANS_DEPTH];
  logic [TW-1:0]          wr_slot;

  assign wr_slot = slot_of(wr_state_i, wr_byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   valid_q <= '0;
    else if (we_i) valid_q[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_s_mem[wr_slot] <= wr_state_i;
      tag_b_mem[wr_slot] <= wr_byte_i;
      next_mem[wr_slot]  <= wr_next_i;
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    logic [TW-1:0] rslot;
    assign rslot        = slot_of(rd_state_i[g], rd_byte_i[g]);
    assign rd_hit_o[g]  = valid_q[rslot] && (tag_s_mem[rslot] == rd_state_i[g])
                          && (tag_b_mem[rslot] == rd_byte_i[g]);
    assign rd_next_o[g] = next_mem[rslot];
  end
endmodule

// File: rtl/mm_path_ctrl.sv
module mm_path_ctrl
  import mm_pkg::*;
#(
  parameter int NUM_STATES = 1024,
  parameter int NUM_PAT    = 32,
  localparam int SW = $clog2(NUM_STATES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               hit_cur_i,
  input  logic [SW-1:0]      next_cur_i,
  input  logic               hit_fail_i,
  input  logic [SW-1:0]      next_fail_i,
  input  logic               hit_root_i,
  input  logic [SW-1:0]      next_root_i,
  input  logic [NUM_PAT-1:0] path_nxt_i,
  input  logic               final_nxt_i,
  output logic [SW-1:0]      nxt_state_o,
  output logic [SW-1:0]      state_q_o,
  output logic [NUM_PAT-1:0] preg_q_o,
  output logic               match_o,
  output logic [NUM_PAT-1:0] match_vec_o
);
  ns_sel_e            ns_sel;
  logic [SW-1:0]      state_q, nxt;
  logic [NUM_PAT-1:0] preg_q, preg_d;
  logic               preg_busy, match_d;

  assign preg_busy = |preg_q;

  // R3 R5 R6: next-state selection
  always_comb begin
    ns_sel = NS_GOTO;
    nxt    = state_q;
    if (valid_i && !hit_cur_i && preg_busy) ns_sel = NS_FAIL;
    if (valid_i) begin
      if (hit_cur_i)                          nxt = next_cur_i;
      else if (ns_sel == NS_FAIL && hit_fail_i) nxt = next_fail_i;
      else if (hit_root_i)                    nxt = next_root_i;
      else                                    nxt = '0;
    end
  end

  assign nxt_state_o = nxt;

  always_comb begin
    preg_d = preg_q;
    if (valid_i) begin
      if (nxt == '0)                  preg_d = '0;
      else if (hit_cur_i && preg_busy) preg_d = preg_q & path_nxt_i;
      else                            preg_d = path_nxt_i;
    end
  end

  assign match_d = valid_i && final_nxt_i && (|preg_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= '0;
      preg_q      <= '0;
      match_o     <= 1'b0;
      match_vec_o <= '0;
    end else begin
      state_q     <= nxt;
      preg_q      <= preg_d;
      match_o     <= match_d;
      match_vec_o <= match_d ? preg_d : '0;
    end
  end

  assign state_q_o = state_q;
  assign preg_q_o  = preg_q;
endmodule

// File: rtl/merged_matcher.sv
module merged_matcher
  import mm_pkg::*;
#(
  parameter int NUM_PAT     = 32,
  parameter int NUM_STATES  = 1024,
  parameter int TRANS_DEPTH = 1024,
  localparam int SW = $clog2(NUM_STATES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [7:0]         byte_i,
  input  logic               tbl_we_i,
  input  logic               tbl_kind_i,
  input  logic [SW-1:0]      tbl_state_i,
  input  logic [NUM_PAT-1:0] tbl_path_i,
  input  logic               tbl_final_i,
  input  logic [SW-1:0]      tbl_fail_i,
  input  logic [7:0]         tbl_byte_i,
  input  logic [SW-1:0]      tbl_next_i,
  output logic               match_o,
  output logic [NUM_PAT-1:0] match_vec_o
);
  localparam int NUM_RD = 3;  // current state, failure target, root

  logic               we_state, we_trans;
  logic [SW-1:0]      state_q, nxt_state, fail_tgt;
  logic [NUM_PAT-1:0] preg_q, path_nxt;
  logic               final_nxt;
  logic [SW-1:0]      rd_state [NUM_RD];
  logic [7:0]         rd_byte  [NUM_RD];
  logic [NUM_RD-1:0]  rd_hit;
  logic [SW-1:0]      rd_next  [NUM_RD];

  assign we_state = tbl_we_i && (tbl_kind_i == KIND_STATE);
  assign we_trans = tbl_we_i && (tbl_kind_i == KIND_TRANS);

  assign rd_state[0] = state_q;
  assign rd_state[1] = fail_tgt;
  assign rd_state[2] = '0;
  for (genvar g = 0; g < NUM_RD; g++) begin : g_key
    assign rd_byte[g] = byte_i;
  end

  mm_state_tbl #(.NUM_STATES(NUM_STATES), .NUM_PAT(NUM_PAT)) u_state_tbl (
    .clk_i        (clk_i),
    .we_i         (we_state),
    .wr_idx_i     (tbl_state_i),
    .wr_path_i    (tbl_path_i),
    .wr_final_i   (tbl_final_i),
    .wr_fail_i    (tbl_fail_i),
    .fail_idx_i   (state_q),
    .fail_o       (fail_tgt),
    .attr_idx_i   (nxt_state),
    .attr_path_o  (path_nxt),
    .attr_final_o (final_nxt)
  );

  mm_trans_tbl #(.NUM_STATES(NUM_STATES), .TRANS_DEPTH(TRANS_DEPTH), .NUM_RD(NUM_RD)) u_trans_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_trans),
    .wr_state_i (tbl_state_i),
    .wr_byte_i  (tbl_byte_i),
    .wr_next_i  (tbl_next_i),
    .rd_state_i (rd_state),
    .rd_byte_i  (rd_byte),
    .rd_hit_o   (rd_hit),
    .rd_next_o  (rd_next)
  );

  mm_path_ctrl #(.NUM_STATES(NUM_STATES), .NUM_PAT(NUM_PAT)) u_path_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .hit_cur_i   (rd_hit[0]),
    .next_cur_i  (rd_next[0]),
    .hit_fail_i  (rd_hit[1]),
    .next_fail_i (rd_next[1]),
    .hit_root_i  (rd_hit[2]),
    .next_root_i (rd_next[2]),
    .path_nxt_i  (path_nxt),
    .final_nxt_i (final_nxt),
    .nxt_state_o (nxt_state),
    .state_q_o   (state_q),
    .preg_q_o    (preg_q),
    .match_o     (match_o),
    .match_vec_o (match_vec_o)
  );
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int NUM_PAT = 32,
  parameter int SW      = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               tbl_we_i,
  input logic               match_o,
  input logic [NUM_PAT-1:0] match_vec_o,
  input logic [SW-1:0]      state_q,
  input logic [NUM_PAT-1:0] preg_q
);
  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (state_q == $past(state_q)) && (preg_q == $past(preg_q))); // R7

  AST_IDLE_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !match_o); // R7

  AST_VEC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> (match_vec_o == '0)); // R10

  AST_ROOT_PATH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == '0) |-> (preg_q == '0)); // R5

  AST_MATCH_ON_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ((match_vec_o & ~preg_q) == '0) && (match_vec_o != '0)); // R2

  AST_WRITE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tbl_we_i && valid_i)); // R8
endmodule

bind merged_matcher mm_checker #(.NUM_PAT(NUM_PAT), .SW(SW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .tbl_we_i    (tbl_we_i),
  .match_o     (match_o),
  .match_vec_o (match_vec_o),
  .state_q     (state_q),
  .preg_q      (preg_q)
);

// File: tb/merged_matcher_test.sv
module merged_matcher_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int NS = 1024;
  localparam int TD = 1024;
  localparam int SW = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [7:0]    byte_i = '0;
  logic          tbl_we_i = 1'b0;
  logic          tbl_kind_i = 1'b0;
  logic [SW-1:0] tbl_state_i = '0;
  logic [NP-1:0] tbl_path_i = '0;
  logic          tbl_final_i = 1'b0;
  logic [SW-1:0] tbl_fail_i = '0;
  logic [7:0]    tbl_byte_i = '0;
  logic [SW-1:0] tbl_next_i = '0;
  logic          match_o;
  logic [NP-1:0] match_vec_o;

  merged_matcher uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .byte_i(byte_i),
    .tbl_we_i(tbl_we_i), .tbl_kind_i(tbl_kind_i), .tbl_state_i(tbl_state_i),
    .tbl_path_i(tbl_path_i), .tbl_final_i(tbl_final_i), .tbl_fail_i(tbl_fail_i),
    .tbl_byte_i(tbl_byte_i), .tbl_next_i(tbl_next_i),
    .match_o(match_o), .match_vec_o(match_vec_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  logic [NP-1:0] m_pv   [NS];
  bit            m_fin  [NS];
  int            m_fail [NS];
  bit            t_val  [TD];
  int            t_s    [TD];
  int            t_b    [TD];
  int            t_n    [TD];
  int            m_state;
  logic [NP-1:0] m_preg;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  function automatic int hslot(int s, int b);
    return (s ^ (b << 2)) & (TD - 1);
  endfunction

  function automatic bit mlook(int s, int b, output int n);
    int k = hslot(s, b);
    n = t_n[k];
    return t_val[k] && t_s[k] == s && t_b[k] == b;
  endfunction

  function automatic logic [NP-1:0] model_step(int b);
    int n, nxt;
    logic [NP-1:0] np;
    if (mlook(m_state, b, n)) begin
      nxt = n;
      np  = (m_preg == '0) ? m_pv[nxt] : (m_preg & m_pv[nxt]);
    end else begin
      if (m_preg != '0 && mlook(m_fail[m_state], b, n)) nxt = n;
      else if (mlook(0, b, n)) nxt = n;
      else nxt = 0;
      np = m_pv[nxt];
    end
    if (nxt == 0) np = '0;
    m_state = nxt;
    m_preg  = np;
    return (m_fin[nxt] && np != '0) ? np : '0;
  endfunction

  task automatic check(string req, logic [NP-1:0] exp_vec);
    logic exp_m = (exp_vec != '0);
    n_chk++;
    if (match_o !== exp_m || match_vec_o !== exp_vec) begin
      n_fail++;
      $display("FAIL %s: match=%0b vec=%h expected match=%0b vec=%h",
               req, match_o, match_vec_o, exp_m, exp_vec);
    end
  endtask

  task automatic wr_state(int s, logic [NP-1:0] pv, bit fin, int fl);
    tbl_we_i = 1'b1; tbl_kind_i = 1'b0; tbl_state_i = SW'(s);
    tbl_path_i = pv; tbl_final_i = fin; tbl_fail_i = SW'(fl);
    @(negedge clk);
    tbl_we_i = 1'b0;
    m_pv[s] = pv; m_fin[s] = fin; m_fail[s] = fl;
  endtask

  task automatic wr_trans(int s, int b, int n);
    int k = hslot(s, b);
    tbl_we_i = 1'b1; tbl_kind_i = 1'b1; tbl_state_i = SW'(s);
    tbl_byte_i = 8'(b); tbl_next_i = SW'(n);
    @(negedge clk);
    tbl_we_i = 1'b0;
    t_val[k] = 1'b1; t_s[k] = s; t_b[k] = b; t_n[k] = n;
  endtask

  task automatic step(bit v, int b, string req);
    logic [NP-1:0] exp_vec;
    valid_i = v;
    byte_i  = 8'(b);
    exp_vec = v ? model_step(b) : '0;
    @(negedge clk);
    valid_i = 1'b0;
    check(req, exp_vec);
  endtask

  task automatic send(string s, string req);
    for (int i = 0; i < s.len(); i++) step(1'b1, int'(s[i]), req);
  endtask

  initial begin
    string alpha = "bcdfghpx";
    int unsigned seed;
    for (int i = 0; i < NS; i++) begin m_pv[i] = '0; m_fin[i] = 1'b0; m_fail[i] = 0; end
    for (int i = 0; i < TD; i++) begin t_val[i] = 1'b0; t_s[i] = 0; t_b[i] = 0; t_n[i] = 0; end
    m_state = 0;
    m_preg  = '0;
    seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    check("R1", '0);  // during reset
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", '0);

    // patterns: bit0 "bcdf", bit1 "pcdg", bit2 "dh"; states 3 and 4 are shared
    wr_state(0, 32'h0, 1'b0, 0);
    wr_state(1, 32'h1, 1'b0, 0);
    wr_state(2, 32'h2, 1'b0, 0);
    wr_state(3, 32'h3, 1'b0, 0);
    wr_state(4, 32'h3, 1'b0, 7);
    wr_state(5, 32'h1, 1'b1, 0);
    wr_state(6, 32'h2, 1'b1, 0);
    wr_state(7, 32'h4, 1'b0, 0);
    wr_state(8, 32'h4, 1'b1, 0);
    wr_trans(0, "b", 1);
    wr_trans(0, "p", 2);
    wr_trans(1, "c", 3);
    wr_trans(2, "c", 3);
    wr_trans(3, "d", 4);
    wr_trans(4, "f", 5);
    wr_trans(4, "g", 6);
    wr_trans(0, "d", 7);
    wr_trans(7, "h", 8);

    send("bcdf", "R2");   // pattern 0 on last byte
    send("pcdg", "R4");   // pattern 1 through merged states
    send("pcdf", "R4");   // no false positive
    send("bcdg", "R9");   // final state reached with zero path
    send("pcdh", "R5");   // miss in shared state, failure to "d"
    send("pcdf", "R3");
    send("dh", "R6");     // miss with cleared path register
    send("pc", "R7");
    repeat (3) step(1'b0, 0, "R7");
    send("dg", "R7");     // walk resumes after idle gap
    send("xxbcdf", "R5");

    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 9);
      if (r == 8) step(1'b0, 0, "R7");
      else        step(1'b1, int'(alpha[r]), "R2");
    end

    // table rewrites while idle
    step(1'b0, 0, "R8");
    wr_state(6, 32'h2, 1'b0, 0);
    send("xpcdg", "R8");  // final flag removed
    wr_trans(8, "f", 5);  // same slot as (0,'d'): evicts it
    send("xdh", "R8");
    send("bcdf", "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule